// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This block sits between a requester and the dynamic phase-adjust port of a PLL. It runs entirely on the scan clock. The requester asks for a number of phase increments on one output counter, in one direction. The sequencer then drives the counter select and direction lines and holds them steady for the whole job. It issues one step pulse per increment. After each pulse it waits for the PLL's done line to fall and then rise again before it moves on.

The PLL samples the step line late and pulls done low only several scan clock edges after the step rises. For that reason the sequencer never treats the done level that is already high as completion. It counts a shift as finished only after it has seen done low and then high again. A pulse of fixed width and a gap of fixed length, both set by parameters, give the PLL the minimum step width and pulse spacing it needs. A timeout guards against a PLL that never answers. A request with a count of zero completes at once.

Top module: `phase_step_seq`

## Requirements
- R1: During and right after reset, `busy`, `pll_step`, `done_cmp` and `err_tmo` are 0, and `pll_sel` and `pll_updn` are 0.
- R2: When idle, a request with a nonzero count is accepted on the clock edge where `req_valid` is 1. At that edge `req_sel` and `req_up` are copied to `pll_sel` and `pll_updn`, and `busy` rises. `pll_sel` and `pll_updn` hold their values for as long as `busy` stays high. The first step pulse rises one cycle after `busy` rises.
- R3: Each step pulse keeps `pll_step` high for exactly STEP_HOLD scan clock cycles, and STEP_HOLD is at least 2.
- R4: A shift is complete only when `pll_done` is sampled high at a rising edge after it has been sampled low at a rising edge since the current pulse rose. While `pll_step` is high, `pll_done` is sampled but cannot complete the shift. A `pll_done` that stays high never completes it.
- R5: After each shift that is not the last, `pll_step` stays low for GAP_CYC cycles and then rises again. A request with count N produces exactly N pulses when every shift completes.
- R6: In the cycle after the edge where the last shift completes, `done_cmp` is 1 for one cycle and `busy` is 0.
- R7: A request with a count of 0, made while idle, produces a one-cycle `done_cmp` in the next cycle. It produces no step pulse, and `busy` stays 0.
- R8: A request made while `busy` is 1 is ignored. It does not change `pll_sel`, `pll_updn` or the number of pulses.
- R9: If no shift completes within TIMEOUT cycles after a step pulse falls, then in the next cycle `err_tmo` is 1 for one cycle, `busy` is 0 and `done_cmp` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_sel | input | SEL_W | Counter select for the request |
| req_up | input | 1 | Direction: 1 shifts up, 0 shifts down |
| req_count | input | CNT_W | Number of phase increments |
| busy | output | 1 | A request is in progress |
| done_cmp | output | 1 | One-cycle pulse when a request finishes |
| err_tmo | output | 1 | One-cycle pulse when a request is aborted by timeout |
| pll_sel | output | SEL_W | Counter select driven to the PLL |
| pll_updn | output | 1 | Direction driven to the PLL |
| pll_step | output | 1 | Step pulse to the PLL |
| pll_done | input | 1 | Done handshake from the PLL |

## Verification
The bench builds the block with STEP_HOLD=3, GAP_CYC=2, TIMEOUT=12, a 4-bit count and DONE_REG=0, so that done feeds the edge tracking directly. A short timeout lets the stuck-PLL abort finish in a few cycles. A 4-bit count lets the largest request, 15 pulses, run in full. A PLL model in the bench makes done fall either while the step is still high or after it has dropped, and it holds done low for one cycle or for several. These cases cover the low sample taken during the pulse and the variable low time.

// File: rtl/pss_pkg.sv
package pss_pkg;
   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_SETUP = 3'd1,
      S_STEP  = 3'd2,
      S_WAIT  = 3'd3,
      S_GAP   = 3'd4
   } pss_state_t;
endpackage

// File: rtl/pss_cycle_timer.sv
// Free-running cycle counter, cleared on request; shared by hold, gap and timeout.
module pss_cycle_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/pss_done_track.sv
// Remembers a low sample of done since the pulse began; flags the following high.
module pss_done_track #(
   parameter bit DONE_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pll_done,
   input  logic arm,
   input  logic track,
   output logic shift_done
);
   logic done_s;
   logic seen_low;

   generate
      if (DONE_REG) begin : g_reg
         logic done_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) done_q <= 1'b1;
            else        done_q <= pll_done;
         end
         assign done_s = done_q;
      end else begin : g_direct
         assign done_s = pll_done;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 seen_low <= 1'b0;
      else if (arm)               seen_low <= 1'b0;
      else if (track && !done_s)  seen_low <= 1'b1;
   end

   assign shift_done = seen_low && done_s;
endmodule

// File: rtl/pss_step_count.sv
// Remaining-increment counter.
module pss_step_count #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);
   logic [W-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rem <= '0;
      else if (load) rem <= load_val;
      else if (dec)  rem <= rem - 1'b1;
   end

   assign last = (rem == W'(1));
endmodule

// File: rtl/phase_step_seq.sv
module phase_step_seq #(
   parameter int SEL_W     = 3,
   parameter int CNT_W     = 8,
   parameter int STEP_HOLD = 3,
   parameter int GAP_CYC   = 2,
   parameter int TIMEOUT   = 1024,
   parameter bit DONE_REG  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [SEL_W-1:0] req_sel,
   input  logic             req_up,
   input  logic [CNT_W-1:0] req_count,
   output logic             busy,
   output logic             done_cmp,
   output logic             err_tmo,
   output logic [SEL_W-1:0] pll_sel,
   output logic             pll_updn,
   output logic             pll_step,
   input  logic             pll_done
);
   import pss_pkg::*;

   localparam int MAX_A = (STEP_HOLD > GAP_CYC) ? STEP_HOLD : GAP_CYC;
   localparam int MAX_C = (MAX_A > TIMEOUT) ? MAX_A : TIMEOUT;
   localparam int TC_W  = $clog2(MAX_C + 1);
   localparam logic [TC_W-1:0] HOLD_LAST = TC_W'(STEP_HOLD - 1);
   localparam logic [TC_W-1:0] GAP_LAST  = TC_W'(GAP_CYC - 1);
   localparam logic [TC_W-1:0] TMO_LAST  = TC_W'(TIMEOUT - 1);

   generate
      if (STEP_HOLD < 2) begin : g_bad_hold
         $error("STEP_HOLD must be at least 2");
      end
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("GAP_CYC must be at least 1");
      end
      if (TIMEOUT < 2) begin : g_bad_tmo
         $error("TIMEOUT must be at least 2");
      end
      if (SEL_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("SEL_W and CNT_W must be positive");
      end
   endgenerate

   pss_state_t      state, nxt;
   logic [TC_W-1:0] tc;
   logic            tc_clr;
   logic            shift_done, last, arm, track, dec;
   logic            accept, zero_cmp, fin, tmo;
   logic            step_q, cmp_q, err_q, up_q;
   logic [SEL_W-1:0] sel_q;

   always_comb begin
      nxt      = state;
      accept   = 1'b0;
      zero_cmp = 1'b0;
      fin      = 1'b0;
      tmo      = 1'b0;
      unique case (state)
         S_IDLE: if (req_valid) begin
            accept = 1'b1;
            if (req_count == '0) zero_cmp = 1'b1;
            else                 nxt = S_SETUP;
         end
         S_SETUP: nxt = S_STEP;
         S_STEP:  if (tc == HOLD_LAST) nxt = S_WAIT;
         S_WAIT: begin
            if (shift_done) begin
               if (last) begin
                  fin = 1'b1;
                  nxt = S_IDLE;
               end else begin
                  nxt = S_GAP;
               end
            end else if (tc == TMO_LAST) begin
               tmo = 1'b1;
               nxt = S_IDLE;
            end
         end
         S_GAP:   if (tc == GAP_LAST) nxt = S_STEP;
         default: nxt = S_IDLE;
      endcase
   end

   assign tc_clr = (nxt != state) || (state == S_IDLE);
   assign arm    = (nxt == S_STEP) && (state != S_STEP);
   assign track  = (state == S_STEP) || (state == S_WAIT);
   assign dec    = (state == S_WAIT) && shift_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         step_q <= 1'b0;
         cmp_q  <= 1'b0;
         err_q  <= 1'b0;
         sel_q  <= '0;
         up_q   <= 1'b0;
      end else begin
         state  <= nxt;
         step_q <= (nxt == S_STEP);
         cmp_q  <= zero_cmp || fin;
         err_q  <= tmo;
         if (accept) begin
            sel_q <= req_sel;
            up_q  <= req_up;
         end
      end
   end

   pss_cycle_timer #(.W(TC_W)) u_timer (
      .clk (clk),
      .rst_n (rst_n),
      .clr (tc_clr),
      .cnt (tc)
   );

   pss_done_track #(.DONE_REG(DONE_REG)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .pll_done   (pll_done),
      .arm        (arm),
      .track      (track),
      .shift_done (shift_done)
   );

   pss_step_count #(.W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (req_count),
      .dec      (dec),
      .last     (last)
   );

   assign busy     = (state != S_IDLE);
   assign done_cmp = cmp_q;
   assign err_tmo  = err_q;
   assign pll_sel  = sel_q;
   assign pll_updn = up_q;
   assign pll_step = step_q;
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
   parameter int SEL_W = 3,
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [CNT_W-1:0] req_count,
   input logic             busy,
   input logic             done_cmp,
   input logic             err_tmo,
   input logic [SEL_W-1:0] pll_sel,
   input logic             pll_updn,
   input logic             pll_step
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |=> (!pll_step && !done_cmp && !err_tmo));

   p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(pll_sel) && $stable(pll_updn)));

   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && req_count != '0) |=> busy);

   p_step_lead_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_step) |-> (busy && $past(busy)));

   p_step_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_step) |-> $past(pll_step, 2));

   p_step_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_step) |=> !pll_step);

   p_finish_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_cmp |-> (!busy && !pll_step));

   p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid && req_count == '0) |=> (done_cmp && !busy));

   p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_tmo |-> (!done_cmp && !busy));
endmodule

bind phase_step_seq pss_checker #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_pss_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_count (req_count),
   .busy      (busy),
   .done_cmp  (done_cmp),
   .err_tmo   (err_tmo),
   .pll_sel   (pll_sel),
   .pll_updn  (pll_updn),
   .pll_step  (pll_step)
);

// File: tb/test_phase_step_seq.sv
module test_phase_step_seq;
   localparam int SEL_W = 3, CNT_W = 4, HOLD = 3, GAP = 2, TMO = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_up = 1'b0, pll_done = 1'b1;
   logic [SEL_W-1:0] req_sel = '0;
   logic [CNT_W-1:0] req_count = '0;
   logic busy, done_cmp, err_tmo, pll_updn, pll_step;
   logic [SEL_W-1:0] pll_sel;

   always #2 clk = ~clk;

   phase_step_seq #(.SEL_W(SEL_W), .CNT_W(CNT_W), .STEP_HOLD(HOLD), .GAP_CYC(GAP),
                    .TIMEOUT(TMO), .DONE_REG(1'b0)) i_phase_step_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .req_up(req_up), .req_count(req_count), .busy(busy), .done_cmp(done_cmp),
      .err_tmo(err_tmo), .pll_sel(pll_sel), .pll_updn(pll_updn),
      .pll_step(pll_step), .pll_done(pll_done));

   int checks = 0, failures = 0, cycles = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: phase 0 idle, 1 setup, 2 step, 3 wait, 4 gap
   int m_ph = 0, m_cnt = 0, m_rem = 0, m_sel = 0, m_up = 0;
   bit m_low = 0, m_cmp = 0, m_err = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_rem = 0; m_sel = 0; m_up = 0;
         m_low = 0; m_cmp = 0; m_err = 0;
      end else begin
         m_cmp = 0; m_err = 0;
         case (m_ph)
            0: if (req_valid) begin
                  m_sel = req_sel; m_up = req_up;
                  if (req_count == 0) m_cmp = 1;
                  else begin m_rem = req_count; m_ph = 1; end
               end
            1: begin m_ph = 2; m_cnt = 0; m_low = 0; end
            2: begin
                  if (!pll_done) m_low = 1;
                  if (m_cnt == HOLD - 1) begin m_ph = 3; m_cnt = 0; end
                  else m_cnt++;
               end
            3: begin
                  if (m_low && pll_done) begin
                     m_rem--;
                     if (m_rem == 0) begin m_ph = 0; m_cmp = 1; end
                     else begin m_ph = 4; m_cnt = 0; end
                  end else if (m_cnt == TMO - 1) begin
                     m_err = 1; m_ph = 0;
                  end else begin
                     if (!pll_done) m_low = 1;
                     m_cnt++;
                  end
               end
            default: begin
                  if (m_cnt == GAP - 1) begin m_ph = 2; m_cnt = 0; m_low = 0; end
                  else m_cnt++;
               end
         endcase
      end
   end

   // Per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 busy", busy, m_ph != 0);
         chk("R2 R8 pll_sel", pll_sel, m_sel);
         chk("R2 R8 pll_updn", pll_updn, m_up);
         chk("R3 R5 pll_step", pll_step, m_ph == 2);
         chk("R6 R7 done_cmp", done_cmp, m_cmp);
         chk("R9 err_tmo", err_tmo, m_err);
      end
   end

   // PLL model: done falls fall_dly edges after the step rises, stays low low_len cycles
   int fall_dly = 2, low_len = 1, dly = 0, lowc = 0, pulses = 0, ncmp = 0, nerr = 0;
   bit stuck = 0, prev_step = 0;

   always @(negedge clk) begin
      if (pll_step && !prev_step) begin
         pulses++;
         if (!stuck) dly = fall_dly;
      end
      prev_step = pll_step;
      if (done_cmp) ncmp++;
      if (err_tmo) nerr++;
      if (dly > 0) begin
         dly--;
         if (dly == 0) begin pll_done <= 1'b0; lowc = low_len; end
      end else if (lowc > 0) begin
         lowc--;
         if (lowc == 0) pll_done <= 1'b1;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic run(int sel, int up, int cnt, bit intrude);
      pulses = 0; ncmp = 0; nerr = 0;
      @(negedge clk);
      req_valid <= 1'b1; req_sel <= SEL_W'(sel); req_up <= up[0]; req_count <= CNT_W'(cnt);
      @(negedge clk);
      req_valid <= 1'b0;
      @(negedge clk);
      if (intrude) begin
         req_valid <= 1'b1; req_sel <= SEL_W'(~sel); req_up <= ~up[0]; req_count <= 4'd7;
         @(negedge clk);
         req_valid <= 1'b0;
      end
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 pll_step", pll_step, 0);
      chk("R1 done_cmp", done_cmp, 0);
      chk("R1 err_tmo", err_tmo, 0);
      chk("R1 pll_sel", pll_sel, 0);
      chk("R1 pll_updn", pll_updn, 0);
      rst_n <= 1'b1;
      repeat (2) @(negedge clk);

      // done drops while step is still high, short low time
      fall_dly = 2; low_len = 1;
      run(5, 1, 1, 0);
      chk("R4 R6 pulses", pulses, 1);
      chk("R6 completions", ncmp, 1);
      chk("R2 sel latched", pll_sel, 5);

      // done drops after step has fallen, long low time
      fall_dly = 6; low_len = 4;
      run(3, 0, 3, 0);
      chk("R5 pulses", pulses, 3);
      chk("R6 completions", ncmp, 1);

      // zero count
      run(6, 1, 0, 0);
      chk("R7 pulses", pulses, 0);
      chk("R7 completions", ncmp, 1);
      chk("R7 sel latched", pll_sel, 6);

      // request while busy
      fall_dly = 3; low_len = 2;
      run(2, 1, 2, 1);
      chk("R8 pulses", pulses, 2);
      chk("R8 sel kept", pll_sel, 2);
      chk("R8 dir kept", pll_updn, 1);

      // PLL never answers: done stays high
      stuck = 1;
      run(1, 0, 2, 0);
      chk("R9 R4 pulses", pulses, 1);
      chk("R9 errors", nerr, 1);
      chk("R9 completions", ncmp, 0);
      stuck = 0;

      // largest count
      fall_dly = 4; low_len = 2;
      run(7, 1, 15, 0);
      chk("R5 max pulses", pulses, 15);
      chk("R6 max completions", ncmp, 1);
      chk("R9 no error", nerr, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule